// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the write side of a sensor front end's configuration space. It loads a bank of eight 8-bit registers through a three-wire serial port: a load strobe, a serial clock and a serial data line. These pins are shared with the pixel output bus. The port only listens while the line-sync input is high, and during that time it tells the bus drivers to release the bus. The three serial pins are sampled in the system clock domain, and their edges are found from the previous sample. Each serial pin must therefore hold each level for at least one system clock.

A frame begins when the load strobe falls. The frame carries eleven bits, most significant first: a 3-bit register address, then eight data bits D7 down to D0. When the strobe rises, the word goes into the addressed register, but only if exactly eleven bits were captured. A shorter frame is dropped. Serial clocks after the eleventh are ignored.

The block decodes three gain codes, three offset codes, the operating-mode fields and the output/test fields, and drives them to the rest of the chip. Two writes have side effects. A mode write with the soft-reset bit set restores every register to its power-up value. Entering power-down keeps all settings except the channel configuration field, which has to be written again once power-down is cleared.

Top module: `ssp_cfg_port`

## Requirements
- R1: Serial frames are accepted only while `lineSync` is high; a frame ending while it is low changes no register. `busRelease` follows `lineSync` (1 = bus released).
- R2: A falling edge of `loadN` starts a new frame and discards any partly captured bits. While `loadN` is low and `lineSync` is high, `serData` is captured on each rising edge of `serClk`.
- R3: A frame is 11 bits sent most significant first: bits 10..8 are the register address (bit 10 first), bits 7..0 are data D7..D0.
- R4: The captured word is written to the addressed register when `loadN` rises. The new value is visible on the outputs from the first system clock edge that samples `loadN` high.
- R5: If fewer than eleven `serClk` rising edges occurred in the frame, the `loadN` rise leaves every register unchanged.
- R6: `serClk` edges after the eleventh in a frame are ignored; only the first eleven bits are used.
- R7: Address map: 0 red gain, 1 red offset, 2 green gain, 3 green offset, 4 blue gain, 5 blue offset, 6 mode, 7 output/test.
- R8: A gain register keeps the 6-bit code from D7..D2 of its frame (D7 most significant) and drops D1..D0; offsets keep all eight bits.
- R9: After `rstN` is asserted, the gain outputs are 0, the offset outputs are 0x40, and all mode and output/test fields are 0.
- R10: Mode register bits: D7 `powerDown`, D5 `topRefExt`, D4 `dcRefExt`, D3 `acCoupled`, D2 `invertPol`, D1..D0 `chanCfg`.
- R11: Output/test register bits: D7 `wideMsb`, D6 `outDisable`, D5 `offRange`, D4 `refCircuitEn`, D3..D0 `testBits`.
- R12: A committed mode write with D6 = 1 returns all eight registers, the mode register included, to their R9 values.
- R13: A mode write with D7 = 1 stores `chanCfg` as 00 while keeping its other fields. As a result, `chanCfg` is 00 whenever `powerDown` is 1 and must be rewritten after power-down is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineSync | input | 1 | Line sync; high enables the serial port |
| loadN | input | 1 | Load strobe, active low for a frame |
| serClk | input | 1 | Serial bit clock (sampled) |
| serData | input | 1 | Serial data |
| busRelease | output | 1 | High when the shared bus must be tri-stated |
| gainRed | output | 6 | Red gain code |
| gainGrn | output | 6 | Green gain code |
| gainBlu | output | 6 | Blue gain code |
| offRed | output | 8 | Red offset code |
| offGrn | output | 8 | Green offset code |
| offBlu | output | 8 | Blue offset code |
| powerDown | output | 1 | Power-down request |
| topRefExt | output | 1 | External top reference select |
| dcRefExt | output | 1 | External DC reference select |
| acCoupled | output | 1 | AC coupling select |
| invertPol | output | 1 | Inverted signal polarity |
| chanCfg | output | 2 | Channel configuration |
| wideMsb | output | 1 | Output format: 8 MSB + 4 LSB when 1 |
| outDisable | output | 1 | Output drivers disabled |
| offRange | output | 1 | Offset range select |
| refCircuitEn | output | 1 | Sensor reference circuit enable |
| testBits | output | 4 | Test controls |

## Verification
Every serial pin goes through one sampling register. A `serClk` or `loadN` edge driven between clock edges is therefore acted on at the next rising clock edge, and a committed write shows on the outputs right after that edge. The bench drives all pins on falling clock edges. It waits two full clocks after raising `loadN` before comparing every output field against its own register model, so a write that arrives one cycle late still meets its check. `busRelease` is combinational and is compared in the same half-cycle that `lineSync` changes.

// File: rtl/ssp_cfg_pkg.sv
package ssp_cfg_pkg;

  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int GAIN_W   = 6;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CFG_W    = 2;

  // register indices whose position is decoded by the fields below
  localparam int IDX_MODE = 6;
  localparam int IDX_TEST = 7;

  // mode register bit positions
  localparam int MB_PDOWN  = 7;
  localparam int MB_SRST   = 6;
  localparam int MB_TOPREF = 5;
  localparam int MB_DCREF  = 4;
  localparam int MB_AC     = 3;
  localparam int MB_POL    = 2;

  // output/test register bit positions
  localparam int TB_FMT  = 7;
  localparam int TB_ODIS = 6;
  localparam int TB_ORNG = 5;
  localparam int TB_REFC = 4;
  localparam int TEST_W  = 4;

  typedef struct packed {
    logic clearFrame;
    logic shiftBit;
    logic commit;
  } frameStrobe_t;

  function automatic logic isGainIdx(int idx);
    return (idx < IDX_MODE) && (idx % 2 == 0);
  endfunction

  function automatic logic isOffsetIdx(int idx);
    return (idx < IDX_MODE) && (idx % 2 == 1);
  endfunction

  function automatic logic [DATA_W-1:0] regDefault(int idx);
    if (isOffsetIdx(idx)) return DATA_W'(1) << (DATA_W - 2);
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] storeValue(int idx, logic [DATA_W-1:0] data);
    logic [DATA_W-1:0] val;
    val = data;
    if (isGainIdx(idx)) val[DATA_W-GAIN_W-1:0] = '0;
    if (idx == IDX_MODE && data[MB_PDOWN]) val[CFG_W-1:0] = '0;
    return val;
  endfunction

endpackage

// File: rtl/ssp_frame_ctrl.sv
module ssp_frame_ctrl
  import ssp_cfg_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineSync,
  input  logic         loadN,
  input  logic         serClk,
  output frameStrobe_t strobe
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic             prevLoad;
  logic             prevSclk;
  logic [CNT_W-1:0] bitCount;
  logic             loadFall;
  logic             loadRise;
  logic             sclkRise;
  logic             frameFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLoad <= 1'b1;
      prevSclk <= 1'b1;
    end else begin
      prevLoad <= loadN;
      prevSclk <= serClk;
    end
  end

  always_comb begin
    loadFall  = prevLoad & ~loadN;
    loadRise  = ~prevLoad & loadN;
    sclkRise  = ~prevSclk & serClk;
    frameFull = (bitCount == CNT_W'(FRAME_BITS));
    strobe.clearFrame = loadFall;
    strobe.shiftBit   = lineSync & ~loadN & ~loadFall & sclkRise & ~frameFull;
    strobe.commit     = lineSync & loadRise & frameFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strobe.clearFrame) begin
      bitCount <= '0;
    end else if (strobe.shiftBit) begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ssp_cfg_datapath.sv
module ssp_cfg_datapath
  import ssp_cfg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  frameStrobe_t                     strobe,
  input  logic                             serData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regFile
);

  logic [FRAME_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  wrAddr;
  logic [DATA_W-1:0]  wrData;
  logic               softReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearFrame) begin
      shiftReg <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], serData};
    end
  end

  always_comb begin
    wrAddr    = shiftReg[FRAME_W-1 -: ADDR_W];
    wrData    = shiftReg[DATA_W-1:0];
    softReset = strobe.commit && (wrAddr == ADDR_W'(IDX_MODE)) && wrData[MB_SRST];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[g] <= regDefault(g);
      end else if (softReset) begin
        regFile[g] <= regDefault(g);
      end else if (strobe.commit && (wrAddr == ADDR_W'(g))) begin
        regFile[g] <= storeValue(g, wrData);
      end
    end
  end

endmodule

// File: rtl/ssp_cfg_port.sv
module ssp_cfg_port
  import ssp_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineSync,
  input  logic              loadN,
  input  logic              serClk,
  input  logic              serData,
  output logic              busRelease,
  output logic [GAIN_W-1:0] gainRed,
  output logic [GAIN_W-1:0] gainGrn,
  output logic [GAIN_W-1:0] gainBlu,
  output logic [DATA_W-1:0] offRed,
  output logic [DATA_W-1:0] offGrn,
  output logic [DATA_W-1:0] offBlu,
  output logic              powerDown,
  output logic              topRefExt,
  output logic              dcRefExt,
  output logic              acCoupled,
  output logic              invertPol,
  output logic [CFG_W-1:0]  chanCfg,
  output logic              wideMsb,
  output logic              outDisable,
  output logic              offRange,
  output logic              refCircuitEn,
  output logic [TEST_W-1:0] testBits
);

  frameStrobe_t                    strobe;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic                            unusedBits;

  ssp_frame_ctrl #(.FRAME_BITS(FRAME_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineSync (lineSync),
    .loadN    (loadN),
    .serClk   (serClk),
    .strobe   (strobe)
  );

  ssp_cfg_datapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .serData (serData),
    .regFile (regFile)
  );

  logic [DATA_W-1:0] modeReg;
  logic [DATA_W-1:0] testReg;

  always_comb begin
    modeReg      = regFile[IDX_MODE];
    testReg      = regFile[IDX_TEST];
    busRelease   = lineSync;
    gainRed      = regFile[0][DATA_W-1 -: GAIN_W];
    gainGrn      = regFile[2][DATA_W-1 -: GAIN_W];
    gainBlu      = regFile[4][DATA_W-1 -: GAIN_W];
    offRed       = regFile[1];
    offGrn       = regFile[3];
    offBlu       = regFile[5];
    powerDown    = modeReg[MB_PDOWN];
    topRefExt    = modeReg[MB_TOPREF];
    dcRefExt     = modeReg[MB_DCREF];
    acCoupled    = modeReg[MB_AC];
    invertPol    = modeReg[MB_POL];
    chanCfg      = modeReg[CFG_W-1:0];
    wideMsb      = testReg[TB_FMT];
    outDisable   = testReg[TB_ODIS];
    offRange     = testReg[TB_ORNG];
    refCircuitEn = testReg[TB_REFC];
    testBits     = testReg[TEST_W-1:0];
    unusedBits   = ^{regFile[0][DATA_W-GAIN_W-1:0], regFile[2][DATA_W-GAIN_W-1:0],
                     regFile[4][DATA_W-GAIN_W-1:0], modeReg[MB_SRST]};
  end

endmodule

// File: rtl/ssp_cfg_port_chk.sv
module ssp_cfg_port_chk
  import ssp_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lineSync,
  input logic              loadN,
  input logic [GAIN_W-1:0] gainRed,
  input logic [GAIN_W-1:0] gainGrn,
  input logic [GAIN_W-1:0] gainBlu,
  input logic [DATA_W-1:0] offRed,
  input logic [DATA_W-1:0] offGrn,
  input logic [DATA_W-1:0] offBlu,
  input logic              powerDown,
  input logic [CFG_W-1:0]  chanCfg,
  input logic [DATA_W-1:0] testView
);

  logic [3*GAIN_W+3*DATA_W+1+CFG_W+DATA_W-1:0] allState;
  assign allState = {gainRed, gainGrn, gainBlu, offRed, offGrn, offBlu,
                     powerDown, chanCfg, testView};

  // R1: nothing is written while the port is closed
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lineSync |=> $stable(allState));

  // R4: registers change only on a sampled strobe rise
  a_r4_commit_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(loadN) |=> $stable(allState));

  // R13: channel configuration is cleared while powered down
  a_r13_pd_cfg: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> (chanCfg == '0));

  // R9: reset drives the documented defaults
  a_r9_reset_defaults: assert property (@(posedge clk)
    !rstN |=> (gainRed == '0 && gainGrn == '0 && gainBlu == '0 &&
               offRed == 8'h40 && offGrn == 8'h40 && offBlu == 8'h40 &&
               !powerDown && chanCfg == '0 && testView == '0));

endmodule

bind ssp_cfg_port ssp_cfg_port_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .lineSync  (lineSync),
  .loadN     (loadN),
  .gainRed   (gainRed),
  .gainGrn   (gainGrn),
  .gainBlu   (gainBlu),
  .offRed    (offRed),
  .offGrn    (offGrn),
  .offBlu    (offBlu),
  .powerDown (powerDown),
  .chanCfg   (chanCfg),
  .testView  ({wideMsb, outDisable, offRange, refCircuitEn, testBits})
);

// File: tb/sim_ssp_cfg_port.sv
module sim_ssp_cfg_port;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineSync = 1'b0;
  logic loadN = 1'b1;
  logic serClk = 1'b0;
  logic serData = 1'b0;

  logic       busRelease;
  logic [5:0] gainRed, gainGrn, gainBlu;
  logic [7:0] offRed, offGrn, offBlu;
  logic       powerDown, topRefExt, dcRefExt, acCoupled, invertPol;
  logic [1:0] chanCfg;
  logic       wideMsb, outDisable, offRange, refCircuitEn;
  logic [3:0] testBits;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  ssp_cfg_port u0 (
    .clk(clk), .rstN(rstN), .lineSync(lineSync), .loadN(loadN),
    .serClk(serClk), .serData(serData), .busRelease(busRelease),
    .gainRed(gainRed), .gainGrn(gainGrn), .gainBlu(gainBlu),
    .offRed(offRed), .offGrn(offGrn), .offBlu(offBlu),
    .powerDown(powerDown), .topRefExt(topRefExt), .dcRefExt(dcRefExt),
    .acCoupled(acCoupled), .invertPol(invertPol), .chanCfg(chanCfg),
    .wideMsb(wideMsb), .outDisable(outDisable), .offRange(offRange),
    .refCircuitEn(refCircuitEn), .testBits(testBits)
  );

  function automatic logic [7:0] defVal(int idx);
    return (idx < 6 && idx % 2 == 1) ? 8'h40 : 8'h00;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) model[i] = defVal(i);
  endtask

  task automatic modelCommit(input logic [2:0] a, input logic [7:0] d);
    if (a == 3'd6 && d[6]) modelReset();
    else if (a < 3'd6 && !a[0]) model[a] = {d[7:2], 2'b00};
    else if (a == 3'd6 && d[7]) model[a] = d & 8'hFC;
    else model[a] = d;
  endtask

  function automatic logic [56:0] expected();
    return {model[0][7:2], model[2][7:2], model[4][7:2], model[1], model[3], model[5],
            model[6][7], model[6][5], model[6][4], model[6][3], model[6][2], model[6][1:0],
            model[7]};
  endfunction

  function automatic logic [56:0] actual();
    return {gainRed, gainGrn, gainBlu, offRed, offGrn, offBlu,
            powerDown, topRefExt, dcRefExt, acCoupled, invertPol, chanCfg,
            wideMsb, outDisable, offRange, refCircuitEn, testBits};
  endfunction

  task automatic checkAll(input string req);
    vectors++;
    if (actual() !== expected()) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, actual(), expected());
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R2 R3: strobe low, then nClk serial bits MSB first, address before data
  task automatic sendFrame(input logic ls, input logic [2:0] a, input logic [7:0] d,
                           input int nClk, input logic [7:0] extra);
    logic [10:0] word;
    word = {a, d};
    @(negedge clk);
    lineSync = ls;
    loadN = 1'b1;
    serClk = 1'b0;
    waitNeg(2);
    loadN = 1'b0;
    waitNeg(2);
    for (int b = 0; b < nClk; b++) begin
      serData = (b < 11) ? word[10-b] : extra[b % 8];
      serClk = 1'b0;
      waitNeg(2);
      serClk = 1'b1;
      waitNeg(2);
    end
    serClk = 1'b0;
    waitNeg(2);
    loadN = 1'b1;
    waitNeg(2);
    if (ls && nClk >= 11) modelCommit(a, d);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    waitNeg(150000);
    misses++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] seedTmp;
    seedTmp = $urandom(32'd4711);
    modelReset();
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(2);
    checkAll("R9 reset defaults");
    checkBit("R1 bus held while line sync low", busRelease, 1'b0);

    @(negedge clk);
    lineSync = 1'b1;
    #1;
    checkBit("R1 bus released while line sync high", busRelease, 1'b1);

    // R7 R8 R10 R11: one write per address, distinct patterns
    sendFrame(1'b1, 3'd0, 8'hB7, 11, 8'h00); checkAll("R8 red gain D7..D2");
    sendFrame(1'b1, 3'd1, 8'h9C, 11, 8'h00); checkAll("R7 red offset");
    sendFrame(1'b1, 3'd2, 8'h5E, 11, 8'h00); checkAll("R7 green gain");
    sendFrame(1'b1, 3'd3, 8'h01, 11, 8'h00); checkAll("R7 green offset");
    sendFrame(1'b1, 3'd4, 8'hFF, 11, 8'h00); checkAll("R8 blue gain max");
    sendFrame(1'b1, 3'd5, 8'hC3, 11, 8'h00); checkAll("R7 blue offset");
    sendFrame(1'b1, 3'd6, 8'h2B, 11, 8'h00); checkAll("R10 mode fields");
    sendFrame(1'b1, 3'd7, 8'hF5, 11, 8'h00); checkAll("R11 output/test fields");
    sendFrame(1'b1, 3'd7, 8'h0A, 11, 8'h00); checkAll("R11 output/test rewrite");

    // R5: ten clocks only
    sendFrame(1'b1, 3'd1, 8'h11, 10, 8'h00); checkAll("R5 short frame dropped");
    // R6: trailing clocks carry other bits
    sendFrame(1'b1, 3'd3, 8'h6D, 15, 8'hA5); checkAll("R6 extra clocks ignored");
    // R1: line sync low during whole frame
    sendFrame(1'b0, 3'd5, 8'h22, 11, 8'h00); checkAll("R1 closed port ignored");
    // R13: power-down clears channel configuration, others kept
    sendFrame(1'b1, 3'd6, 8'hBB, 11, 8'h00); checkAll("R13 power-down entry");
    checkBit("R13 chanCfg low bit", chanCfg[0], 1'b0);
    sendFrame(1'b1, 3'd6, 8'h22, 11, 8'h00); checkAll("R13 config rewritten");
    // R12: soft reset
    sendFrame(1'b1, 3'd6, 8'h5F, 11, 8'h00); checkAll("R12 soft reset");
    sendFrame(1'b1, 3'd2, 8'hAC, 11, 8'h00); checkAll("R4 write after soft reset");

    for (int n = 0; n < 260; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      int sel, nClk;
      logic ls;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 3'd6 && ($urandom % 4) != 0) d[6] = 1'b0;
      sel = int'($urandom % 10);
      nClk = (sel == 0) ? 6 + int'($urandom % 5) : (sel == 1) ? 12 + int'($urandom % 4) : 11;
      ls = (($urandom % 10) != 0);
      sendFrame(ls, a, d, nClk, 8'($urandom));
      checkAll(nClk < 11 ? "R5 random" : nClk > 11 ? "R6 random" : ls ? "R4 random" : "R1 random");
    end
    finishRun();
  end

endmodule